// File: doc/BRIEF.md
# Opcode-Decoded Eight-Bit ALU

This block is the arithmetic and logic datapath of a small eight-bit processor. Two operands, A and B, go through a chain of four-bit function-generator slices. Each slice offers sixteen logic functions and sixteen arithmetic functions, and an active-low carry ripples from one slice to the next. The sequencer does not drive the slices' function-select, mode and carry-in controls directly. A 32-entry control table produces them, and it is addressed by the low nibble of the current opcode together with the stored carry flag. As a result, every opcode that shares a low nibble selects the same ALU operation. The upper nibble is free to encode addressing modes: 0x02, 0x12 and 0xF2 are all NAND.

The ALU result is combinational and always follows the current opcode and operands. Nothing is committed until a strobe asks for it. A result strobe places the result on the bus output for one cycle. A flag strobe captures the zero, carry and sign indications in a four-bit flag register. The flag register can also be restored whole from a data input, so that it can be saved and reloaded. The stored carry feeds back into the control table, which makes add-with-carry and subtract-with-borrow chain across bytes.

Top module: `opalu_top`

## Requirements
- R1: Only `opcode[3:0]` selects the operation. Two opcodes with equal low nibbles give identical `result` and identical flags for the same operands and flags.
- R2: The low-nibble encodings are: 0 A+B, 1 A+B+carry, 2 NAND, 3 A-B, 4 AND, 5 OR, 6 A-B-borrow, 7 XOR, 8 NOT A, 9 NOR, A XNOR, B pass B, C pass A, D A+1, E A-1, F zero. All results are modulo 256.
- R3: Nibbles 1 and 6 take their carry-in from stored flag bit 1. When that bit is 0, nibble 1 adds one. When that bit is 1, nibble 6 subtracts one more.
- R4: The carry indication is active low and is stored in flag bit 1. The bit is 0 when an addition overflows 8 bits, and 0 when a subtraction needs no borrow (A>=B for nibble 3). For nibble D it is 0 only at A=0xFF. For nibble E it is 0 unless A=0. Every logic operation (2,4,5,7,8,9,A,B,C,F) stores 1.
- R5: Flag bit 0 holds 1 when the latched result was zero. Flag bit 2 holds the latched result's MSB.
- R6: The flags change only on a clock edge where `flag_latch` or `flag_restore` is high. At all other times they hold their value.
- R7: With `flag_restore` high, all four flag bits load `flag_din` at the edge, and this takes priority over `flag_latch`. A `flag_latch` on its own writes flag bit 3 as 0.
- R8: `res_oe` high at an edge makes `bus_drive` 1 and `bus_data` equal to that cycle's result after the edge. Otherwise both outputs are 0 after the edge.
- R9: After synchronous reset, `flags` is 4'b0010 (no carry), `bus_drive` is 0 and `bus_data` is 0.
- R10: `result` follows the current opcode, operands and stored flags within the same cycle, with no register in its path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Current opcode; only bits [3:0] reach the control table |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| res_oe | input | 1 | Place the result on the bus for the next cycle |
| flag_latch | input | 1 | Capture ALU zero, carry and sign into the flags |
| flag_restore | input | 1 | Load all flag bits from `flag_din` |
| flag_din | input | 4 | Flag value to restore |
| result | output | 8 | Combinational ALU result |
| bus_data | output | 8 | Registered bus value, 0 when released |
| bus_drive | output | 1 | High while the block drives the bus |
| flags | output | 4 | {spare, sign, carry_n, zero} |

## Verification
The bench builds the block with its default 8-bit width and 4-bit slices, so that there are two slices. This brings the ripple of the active-low carry between slices within reach, as in A+B=0x124 and in borrows through the low nibble. Random opcodes, operands and restored flags cover all 32 control-table entries. Directed cases cover the two-byte add-with-carry and compare-with-borrow chains and the upper-nibble aliasing of opcodes.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
  localparam int NIB_W = 4;
  localparam int FLAG_W = 4;
  localparam int FL_Z = 0;
  localparam int FL_CN = 1;
  localparam int FL_N = 2;
  localparam int FL_SPARE = 3;
  localparam logic [FLAG_W-1:0] FLAG_RST = 4'b0010;

  typedef struct packed {
    logic [3:0] fsel;
    logic       logic_mode;
    logic       cin_n;
  } alu_ctl_t;

  localparam logic [3:0] NB_ADD  = 4'h0;
  localparam logic [3:0] NB_ADDC = 4'h1;
  localparam logic [3:0] NB_NAND = 4'h2;
  localparam logic [3:0] NB_SUB  = 4'h3;
  localparam logic [3:0] NB_AND  = 4'h4;
  localparam logic [3:0] NB_OR   = 4'h5;
  localparam logic [3:0] NB_SUBC = 4'h6;
  localparam logic [3:0] NB_XOR  = 4'h7;
  localparam logic [3:0] NB_NOTA = 4'h8;
  localparam logic [3:0] NB_NOR  = 4'h9;
  localparam logic [3:0] NB_XNOR = 4'hA;
  localparam logic [3:0] NB_PASB = 4'hB;
  localparam logic [3:0] NB_PASA = 4'hC;
  localparam logic [3:0] NB_INC  = 4'hD;
  localparam logic [3:0] NB_DEC  = 4'hE;
  localparam logic [3:0] NB_CLR  = 4'hF;
endpackage

// File: rtl/opalu_ctl_rom.sv
module opalu_ctl_rom
  import opalu_pkg::*;
(
  input  logic [NIB_W-1:0] op_nib,
  input  logic             carry_n_q,
  output alu_ctl_t         ctl
);
  always_comb begin
    ctl = '{fsel: 4'h0, logic_mode: 1'b0, cin_n: 1'b1};
    unique case (op_nib)
      NB_ADD:  ctl = '{fsel: 4'h9, logic_mode: 1'b0, cin_n: 1'b1};
      NB_ADDC: ctl = '{fsel: 4'h9, logic_mode: 1'b0, cin_n: carry_n_q};
      NB_NAND: ctl = '{fsel: 4'h4, logic_mode: 1'b1, cin_n: 1'b1};
      NB_SUB:  ctl = '{fsel: 4'h6, logic_mode: 1'b0, cin_n: 1'b0};
      NB_AND:  ctl = '{fsel: 4'hB, logic_mode: 1'b1, cin_n: 1'b1};
      NB_OR:   ctl = '{fsel: 4'hE, logic_mode: 1'b1, cin_n: 1'b1};
      NB_SUBC: ctl = '{fsel: 4'h6, logic_mode: 1'b0, cin_n: carry_n_q};
      NB_XOR:  ctl = '{fsel: 4'h6, logic_mode: 1'b1, cin_n: 1'b1};
      NB_NOTA: ctl = '{fsel: 4'h0, logic_mode: 1'b1, cin_n: 1'b1};
      NB_NOR:  ctl = '{fsel: 4'h1, logic_mode: 1'b1, cin_n: 1'b1};
      NB_XNOR: ctl = '{fsel: 4'h9, logic_mode: 1'b1, cin_n: 1'b1};
      NB_PASB: ctl = '{fsel: 4'hA, logic_mode: 1'b1, cin_n: 1'b1};
      NB_PASA: ctl = '{fsel: 4'hF, logic_mode: 1'b1, cin_n: 1'b1};
      NB_INC:  ctl = '{fsel: 4'h0, logic_mode: 1'b0, cin_n: 1'b0};
      NB_DEC:  ctl = '{fsel: 4'hF, logic_mode: 1'b0, cin_n: 1'b1};
      NB_CLR:  ctl = '{fsel: 4'h3, logic_mode: 1'b1, cin_n: 1'b1};
      default: ctl = '{fsel: 4'h0, logic_mode: 1'b0, cin_n: 1'b1};
    endcase
  end
endmodule

// File: rtl/opalu_slice.sv
module opalu_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic [3:0]    fsel,
  input  logic          logic_mode,
  input  logic          cin_n,
  output logic [SW-1:0] f,
  output logic          co_n
);
  logic [SW-1:0] term_p, term_g, lf;
  logic [SW:0]   sum;

  // Arithmetic: F = P + G + carry, P/G chosen by the select bits
  always_comb begin
    term_p = a | (b & {SW{fsel[0]}}) | (~b & {SW{fsel[1]}});
    term_g = (a & ~b & {SW{fsel[2]}}) | (a & b & {SW{fsel[3]}});
    sum    = {1'b0, term_p} + {1'b0, term_g} + {{SW{1'b0}}, ~cin_n};
  end

  always_comb begin
    unique case (fsel)
      4'h0: lf = ~a;
      4'h1: lf = ~(a | b);
      4'h2: lf = ~a & b;
      4'h3: lf = '0;
      4'h4: lf = ~(a & b);
      4'h5: lf = ~b;
      4'h6: lf = a ^ b;
      4'h7: lf = a & ~b;
      4'h8: lf = ~a | b;
      4'h9: lf = ~(a ^ b);
      4'hA: lf = b;
      4'hB: lf = a & b;
      4'hC: lf = '1;
      4'hD: lf = a | ~b;
      4'hE: lf = a | b;
      4'hF: lf = a;
      default: lf = a;
    endcase
  end

  assign f    = logic_mode ? lf : sum[SW-1:0];
  assign co_n = logic_mode ? 1'b1 : ~sum[SW];
endmodule

// File: rtl/opalu_flags.sv
module opalu_flags
  import opalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic              restore,
  input  logic [FLAG_W-1:0] din,
  input  logic              z_in,
  input  logic              cn_in,
  input  logic              n_in,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst)           flags_q <= FLAG_RST;
    else if (restore)  flags_q <= din;
    else if (latch) begin
      flags_q[FL_Z]     <= z_in;
      flags_q[FL_CN]    <= cn_in;
      flags_q[FL_N]     <= n_in;
      flags_q[FL_SPARE] <= 1'b0;
    end
  end

  // R6: no strobe, no change
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!latch && !restore) |=> $stable(flags_q));
  // R7: restore wins over latch
  a_r7_restore: assert property (@(posedge clk) disable iff (rst)
    restore |=> (flags_q == $past(din)));
  // R5: zero and sign captured from the ALU
  a_r5_zero_sign: assert property (@(posedge clk) disable iff (rst)
    (latch && !restore) |=> (flags_q[FL_Z] == $past(z_in)) && (flags_q[FL_N] == $past(n_in)));
endmodule

// File: rtl/opalu_top.sv
module opalu_top
  import opalu_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int SLICE_W = 4,
  parameter int OP_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic              res_oe,
  input  logic              flag_latch,
  input  logic              flag_restore,
  input  logic [FLAG_W-1:0] flag_din,
  output logic [WIDTH-1:0]  result,
  output logic [WIDTH-1:0]  bus_data,
  output logic              bus_drive,
  output logic [FLAG_W-1:0] flags
);
  localparam int NSLICE = WIDTH / SLICE_W;

  alu_ctl_t          ctl;
  logic [NSLICE:0]   chain_n;
  logic              res_zero;

  opalu_ctl_rom u_rom (
    .op_nib    (opcode[NIB_W-1:0]),
    .carry_n_q (flags[FL_CN]),
    .ctl       (ctl)
  );

  assign chain_n[0] = ctl.cin_n;

  for (genvar gi = 0; gi < NSLICE; gi++) begin : g_slice
    opalu_slice #(.SW(SLICE_W)) u_slice (
      .a          (op_a[gi*SLICE_W +: SLICE_W]),
      .b          (op_b[gi*SLICE_W +: SLICE_W]),
      .fsel       (ctl.fsel),
      .logic_mode (ctl.logic_mode),
      .cin_n      (chain_n[gi]),
      .f          (result[gi*SLICE_W +: SLICE_W]),
      .co_n       (chain_n[gi+1])
    );
  end

  assign res_zero = (result == '0);

  opalu_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .latch   (flag_latch),
    .restore (flag_restore),
    .din     (flag_din),
    .z_in    (res_zero),
    .cn_in   (chain_n[NSLICE]),
    .n_in    (result[WIDTH-1]),
    .flags_q (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data  <= '0;
      bus_drive <= 1'b0;
    end else begin
      bus_drive <= res_oe;
      bus_data  <= res_oe ? result : '0;
    end
  end

  // R2: nibble 2 is NAND on the slice outputs
  a_r2_nand: assert property (@(posedge clk) disable iff (rst)
    (opcode[3:0] == NB_NAND) |-> (result == ~(op_a & op_b)));
  // R2/R4: nibble 3 yields A-B and no-borrow reported active low
  a_r4_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (opcode[3:0] == NB_SUB) |-> (result == WIDTH'(op_a - op_b)) && (chain_n[NSLICE] == (op_a < op_b)));
  // R4: logic ops store carry_n = 1
  a_r4_logic_carry: assert property (@(posedge clk) disable iff (rst)
    (ctl.logic_mode && flag_latch && !flag_restore) |=> flags[FL_CN]);
  // R8: bus released when not enabled
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    !res_oe |=> (!bus_drive && bus_data == '0));
  // R8: enabled bus carries the prior result
  a_r8_drive: assert property (@(posedge clk) disable iff (rst)
    res_oe |=> (bus_drive && bus_data == $past(result)));
endmodule

// File: tb/test_opalu_top.sv
module test_opalu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode = '0, op_a = '0, op_b = '0;
  logic       res_oe = 1'b0, flag_latch = 1'b0, flag_restore = 1'b0;
  logic [3:0] flag_din = '0;
  logic [7:0] result, bus_data;
  logic       bus_drive;
  logic [3:0] flags;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  opalu_top i_opalu_top (
    .clk(clk), .rst(rst), .opcode(opcode), .op_a(op_a), .op_b(op_b),
    .res_oe(res_oe), .flag_latch(flag_latch), .flag_restore(flag_restore),
    .flag_din(flag_din), .result(result), .bus_data(bus_data),
    .bus_drive(bus_drive), .flags(flags)
  );

  // returns {carry_out_active_high, result}
  function automatic logic [8:0] model(input logic [3:0] nib, input logic [7:0] a,
                                       input logic [7:0] b, input logic cn);
    logic [8:0] c1;
    c1 = {8'h0, ~cn};
    case (nib)
      4'h0: return {1'b0, a} + {1'b0, b};
      4'h1: return {1'b0, a} + {1'b0, b} + c1;
      4'h2: return {1'b0, ~(a & b)};
      4'h3: return {1'b0, a} + {1'b0, ~b} + 9'd1;
      4'h4: return {1'b0, a & b};
      4'h5: return {1'b0, a | b};
      4'h6: return {1'b0, a} + {1'b0, ~b} + c1;
      4'h7: return {1'b0, a ^ b};
      4'h8: return {1'b0, ~a};
      4'h9: return {1'b0, ~(a | b)};
      4'hA: return {1'b0, ~(a ^ b)};
      4'hB: return {1'b0, b};
      4'hC: return {1'b0, a};
      4'hD: return {1'b0, a} + 9'd1;
      4'hE: return {1'b0, a} + 9'h0FF;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [3:0] exp_flags(input logic [8:0] m);
    return {1'b0, m[7], ~m[8], (m[7:0] == 8'h00)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [3:0] v);
    @(negedge clk);
    flag_restore = 1'b1; flag_din = v;
    @(negedge clk);
    flag_restore = 1'b0;
  endtask

  // apply one operation with both strobes, check result, flags and bus
  task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                        input string req);
    logic [8:0] m;
    @(negedge clk);
    m = model(op[3:0], a, b, flags[1]);
    opcode = op; op_a = a; op_b = b; res_oe = 1'b1; flag_latch = 1'b1;
    #1;
    check({req, " R10 result"}, result, m[7:0]);
    @(negedge clk);
    res_oe = 1'b0; flag_latch = 1'b0;
    check({req, " R4/R5 flags"}, flags, exp_flags(m));
    check({req, " R8 bus"}, {bus_drive, bus_data}, {1'b1, m[7:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] f0;
    logic [7:0] r0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 reset flags", flags, 4'b0010);
    check("R9 reset bus", {bus_drive, bus_data}, 9'h000);

    // R1: opcode aliasing by low nibble
    set_flags(4'b0010);
    run_op(8'h02, 8'hF0, 8'h3C, "R1 R2 nand 02");
    set_flags(4'b0010);
    run_op(8'h12, 8'hF0, 8'h3C, "R1 nand 12");
    set_flags(4'b0010);
    run_op(8'hF2, 8'hF0, 8'hFF, "R1 nand F2");

    // R3: two-byte add 0x1234 + 0x01F0 -> low 0x24 with carry, high 0x14
    set_flags(4'b0010);
    run_op(8'h00, 8'h34, 8'hF0, "R3 add low");
    check("R3 carry stored", flags[1], 1'b0);
    run_op(8'h01, 8'h12, 8'h01, "R3 addc high");
    check("R3 addc value", bus_data, 8'h14);

    // R3: compare 0xAA01 with 0xAA02 -> borrow, not equal
    run_op(8'h03, 8'h01, 8'h02, "R3 cmp low");
    run_op(8'h26, 8'hAA, 8'hAA, "R3 cmpc high");
    check("R3 cmpc carry_n", flags[1], 1'b1);
    check("R3 cmpc zero", flags[0], 1'b0);

    // R4: inc/dec edges
    run_op(8'h0D, 8'hFF, 8'h00, "R4 inc FF");
    run_op(8'h0E, 8'h00, 8'h00, "R4 dec 00");

    // R6/R8: no strobes -> flags hold, bus released
    set_flags(4'b1101);
    @(negedge clk);
    opcode = 8'h00; op_a = 8'h00; op_b = 8'h00;
    @(negedge clk);
    check("R6 flags hold", flags, 4'b1101);
    check("R8 bus released", {bus_drive, bus_data}, 9'h000);

    // R7: restore wins over latch
    @(negedge clk);
    flag_restore = 1'b1; flag_latch = 1'b1; flag_din = 4'b1010;
    @(negedge clk);
    flag_restore = 1'b0; flag_latch = 1'b0;
    check("R7 restore priority", flags, 4'b1010);

    // random mix, all nibbles and stored carries
    for (int i = 0; i < 600; i++) begin
      f0 = 4'($urandom());
      set_flags(f0);
      run_op(8'($urandom()), 8'($urandom()), 8'($urandom()), "R2 random");
    end

    // R10: result combinational without strobes
    @(negedge clk);
    opcode = 8'h07; op_a = 8'h5A; op_b = 8'hFF;
    #1;
    r0 = result;
    check("R10 comb xor", r0, 8'hA5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule